// File: doc/BRIEF.md
# Converter Reset and Power-Mode Sequencer

This block decides when the digital part of a data converter is held in reset, asleep or running. It runs on the converter's master clock. It watches two supply-good flags, an active-low reset pin, an active-low power-down pin, and the decoded serial commands, which arrive as a command code together with a running count of rising serial-clock edges. From these it produces four things: a global internal reset, a load strobe that returns the configuration registers to their defaults, a one-cycle pulse that restarts the conversion timing, and a two-bit power-mode code. It also gives a single-cycle active-low data-ready strobe once the settling time that follows a restart has elapsed.

The sources are ranked. Missing supplies and the power-on hold win over everything else. The power-down pin comes next, then the reset pin, then a reset command. Standby and wake-up commands rank lowest. Each way out of a reset or power-down state passes through a settling interval. Leaving through a wake-up command makes that interval two master-clock cycles shorter. Both delay lengths are parameters, so a bench can shorten them.

Top module: `cseq_top`

## Requirements
- R1: While either supply flag is low, `gbl_rst_o` and `cfg_load_o` are high and `pwr_mode_o` is 3 (reset). Once both flags are high, `gbl_rst_o` stays high for exactly `POR_CYCLES` clock samples and then drops. If a flag falls later, the hold starts again.
- R2: The supplies may come up in either order. With only one flag high, the global reset is never released.
- R3: The reset pin is first passed through a synchroniser. If it stays low for fewer than `RST_MIN_LOW` (2) synchronised cycles, it has no effect. If it stays low for that many cycles or more, the block enters reset (`cfg_load_o` high, mode 3) and remains there until the pin returns high.
- R4: A reset command is command code 1. It takes effect at the first clock edge that samples the edge count at 8 while that code is present. `cfg_load_o` is then high for exactly one cycle. Edge counts 0 to 7 have no effect.
- R5: `conv_sync_o` pulses for one cycle when the block leaves reset, the power-on hold or power-down, and when a wake-up ends standby.
- R6: After a restart that is not a wake-up, `drdy_n_o` goes low for exactly one cycle. That cycle comes `SETTLE_CYCLES` cycles after the sync pulse, and the mode reads 0 (run) from then on.
- R7: After a wake-up command (code 3, edge count 8) ends standby, the data-ready strobe comes `SETTLE_CYCLES - 2` cycles after the sync pulse.
- R8: Once the power-down pin is synchronised low, the mode is 2 and `cfg_load_o` is high. When the pin is released, the block restarts with the full settling time.
- R9: A standby command (code 2, edge count 8) sets mode 1 and leaves `cfg_load_o` low. While in standby, no data-ready appears, but a reset command is still accepted.
- R10: A wake-up command given while the block is running has no effect: there is no sync pulse, no data-ready, and the mode stays run.
- R11: A command acts only once, even if its code and an edge count of 8 stay present for many cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| sup_ana_ok_i | input | 1 | Analog supply good, synchronous to clk |
| sup_dig_ok_i | input | 1 | Digital supply good, synchronous to clk |
| rst_pin_n_i | input | 1 | Asynchronous reset pin, active low |
| pdn_pin_n_i | input | 1 | Asynchronous power-down pin, active low |
| cmd_code_i | input | 2 | Decoded command: 0 none, 1 reset, 2 standby, 3 wake-up |
| sclk_edges_i | input | 4 | Rising serial-clock edges seen in the current command |
| gbl_rst_o | output | 1 | Global internal reset (power-on hold) |
| cfg_load_o | output | 1 | Load default values into the configuration registers |
| conv_sync_o | output | 1 | One-cycle conversion restart pulse |
| pwr_mode_o | output | 2 | 0 run, 1 standby, 2 power-down, 3 reset |
| drdy_n_o | output | 1 | First data-ready strobe, active low, one cycle |

## Verification
The assertions take three things for granted about the inputs. The supply flags, the command code and the edge count are already synchronous to the master clock. The command code stays stable while the edge count reads 8. The edge count climbs to 8 once per command and then returns low. The bench changes every input just after a rising edge and samples one nanosecond later, which keeps it inside these assumptions. It also leaves the code and the count at 8 for many cycles in some tests, to show that a held command acts only once. The pins are deliberately driven asynchronously relative to the design's view, and the bench checks only whether a reset happened, not its exact cycle, so those checks hold whatever phase the synchroniser sees.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

    localparam int unsigned SCLK_W = 4;
    localparam logic [SCLK_W-1:0] CMD_LAST_EDGE = 4'd8;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_PDN    = 3'd1,
        ST_RST    = 3'd2,
        ST_SETTLE = 3'd3,
        ST_RUN    = 3'd4,
        ST_STBY   = 3'd5
    } seq_st_e;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_RESET   = 2'd1,
        CMD_STANDBY = 2'd2,
        CMD_WAKE    = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_STBY = 2'd1,
        MODE_PDN  = 2'd2,
        MODE_RST  = 2'd3
    } pmode_e;

    typedef struct packed {
        logic por_ok;
        logic pdn_hold;
        logic rst_hold;
        logic cmd_fire;
        cmd_e cmd;
    } seq_req_t;

    function automatic pmode_e mode_of(seq_st_e s);
        case (s)
            ST_STBY:           return MODE_STBY;
            ST_PDN:            return MODE_PDN;
            ST_SETTLE, ST_RUN: return MODE_RUN;
            default:           return MODE_RST;
        endcase
    endfunction

    function automatic logic clears_cfg(seq_st_e s);
        return (s == ST_HOLD) || (s == ST_PDN) || (s == ST_RST);
    endfunction

endpackage

// File: rtl/cseq_pin_filter.sv
module cseq_pin_filter #(
    parameter int unsigned STAGES  = 2,
    parameter int unsigned MIN_LOW = 2
) (
    input  logic clk_i,
    input  logic srst_i,
    input  logic pin_n_i,
    output logic hold_o
);
    localparam int unsigned RW = $clog2(MIN_LOW + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(MIN_LOW);

    logic [STAGES-1:0] chain;
    logic              pin_low;
    logic [RW-1:0]     run;

    always_ff @(posedge clk_i) begin
        chain[0] <= pin_n_i;
        for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
        end
    end

    assign pin_low = !chain[STAGES-1];

    always_ff @(posedge clk_i) begin
        if (srst_i || !pin_low) begin
            run <= '0;
        end else if (run != RUN_MAX) begin
            run <= run + 1'b1;
        end
    end

    assign hold_o = (run == RUN_MAX);

    // R3: a qualified hold always follows a synchronised low sample
    p_pin_width_r3: assert property (@(posedge clk_i) disable iff (srst_i)
        hold_o |-> $past(pin_low));

endmodule

// File: rtl/cseq_por_hold.sv
module cseq_por_hold #(
    parameter int unsigned HOLD_CYCLES = 65536
) (
    input  logic clk_i,
    input  logic srst_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] CNT_END = CW'(HOLD_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            cnt <= '0;
        end else if (cnt != CNT_END) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done_o = (cnt == CNT_END);

    // R1: once released, the hold stays released while supplies stay good
    p_por_sticky_r1: assert property (@(posedge clk_i) disable iff (srst_i)
        done_o |=> done_o);

endmodule

// File: rtl/cseq_settle_timer.sv
module cseq_settle_timer #(
    parameter int unsigned FULL_CYCLES = 258436,
    parameter int unsigned WAKE_TRIM   = 2
) (
    input  logic clk_i,
    input  logic srst_i,
    input  logic run_i,
    input  logic load_i,
    input  logic trim_i,
    output logic fire_o
);
    localparam int unsigned TW = $clog2(FULL_CYCLES + 1);
    localparam logic [TW-1:0] FULL_V  = TW'(FULL_CYCLES);
    localparam logic [TW-1:0] SHORT_V = TW'(FULL_CYCLES - WAKE_TRIM);
    localparam logic [TW-1:0] ONE_V   = TW'(1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk_i) begin
        if (srst_i || !run_i) begin
            cnt    <= '0;
            fire_o <= 1'b0;
        end else if (load_i) begin
            cnt    <= trim_i ? SHORT_V : FULL_V;
            fire_o <= 1'b0;
        end else begin
            fire_o <= (cnt == ONE_V);
            if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R6: the settle strobe is a single cycle
    p_fire_single_r6: assert property (@(posedge clk_i) disable iff (srst_i)
        fire_o |=> !fire_o);

    // R6: a strobe is only produced while settling was requested
    p_fire_in_run_r6: assert property (@(posedge clk_i) disable iff (srst_i)
        fire_o |-> $past(run_i));

endmodule

// File: rtl/cseq_top.sv
module cseq_top #(
    parameter int unsigned POR_CYCLES    = 65536,
    parameter int unsigned SETTLE_CYCLES = 258436,
    parameter int unsigned WAKE_TRIM     = 2,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned RST_MIN_LOW   = 2
) (
    input  logic       clk,
    input  logic       sup_ana_ok_i,
    input  logic       sup_dig_ok_i,
    input  logic       rst_pin_n_i,
    input  logic       pdn_pin_n_i,
    input  logic [1:0] cmd_code_i,
    input  logic [3:0] sclk_edges_i,
    output logic       gbl_rst_o,
    output logic       cfg_load_o,
    output logic       conv_sync_o,
    output logic [1:0] pwr_mode_o,
    output logic       drdy_n_o
);
    import cseq_pkg::*;

    logic     srst;
    logic     cmd_hit, cmd_hit_q;
    logic     settle_done;
    logic     enter_settle;
    logic     sync_q;
    seq_req_t req;
    seq_st_e  st, nxt;

    assign srst = !(sup_ana_ok_i && sup_dig_ok_i);

    cseq_por_hold #(.HOLD_CYCLES(POR_CYCLES)) u_por (
        .clk_i  (clk),
        .srst_i (srst),
        .done_o (req.por_ok)
    );

    cseq_pin_filter #(.STAGES(SYNC_STAGES), .MIN_LOW(RST_MIN_LOW)) u_rst_pin (
        .clk_i   (clk),
        .srst_i  (srst),
        .pin_n_i (rst_pin_n_i),
        .hold_o  (req.rst_hold)
    );

    cseq_pin_filter #(.STAGES(SYNC_STAGES), .MIN_LOW(1)) u_pdn_pin (
        .clk_i   (clk),
        .srst_i  (srst),
        .pin_n_i (pdn_pin_n_i),
        .hold_o  (req.pdn_hold)
    );

    // command acts on the first clock edge that sees the last serial edge
    assign cmd_hit      = (cmd_code_i != CMD_NONE) && (sclk_edges_i == CMD_LAST_EDGE);
    assign req.cmd_fire = cmd_hit && !cmd_hit_q;
    assign req.cmd      = cmd_e'(cmd_code_i);

    always_ff @(posedge clk) begin
        if (srst) cmd_hit_q <= 1'b0;
        else      cmd_hit_q <= cmd_hit;
    end

    always_comb begin
        nxt = st;
        if (!req.por_ok) begin
            nxt = ST_HOLD;
        end else if (req.pdn_hold) begin
            nxt = ST_PDN;
        end else if (req.rst_hold) begin
            nxt = ST_RST;
        end else if (req.cmd_fire && req.cmd == CMD_RESET) begin
            nxt = ST_RST;
        end else begin
            case (st)
                ST_HOLD, ST_PDN, ST_RST: nxt = ST_SETTLE;
                ST_SETTLE: begin
                    if (req.cmd_fire && req.cmd == CMD_STANDBY) nxt = ST_STBY;
                    else if (settle_done)                       nxt = ST_RUN;
                end
                ST_RUN: begin
                    if (req.cmd_fire && req.cmd == CMD_STANDBY) nxt = ST_STBY;
                end
                ST_STBY: begin
                    if (req.cmd_fire && req.cmd == CMD_WAKE) nxt = ST_SETTLE;
                end
                default: nxt = ST_HOLD;
            endcase
        end
    end

    assign enter_settle = (nxt == ST_SETTLE) && (st != ST_SETTLE);

    always_ff @(posedge clk) begin
        if (srst) begin
            st     <= ST_HOLD;
            sync_q <= 1'b0;
        end else begin
            st     <= nxt;
            sync_q <= enter_settle;
        end
    end

    cseq_settle_timer #(.FULL_CYCLES(SETTLE_CYCLES), .WAKE_TRIM(WAKE_TRIM)) u_settle (
        .clk_i  (clk),
        .srst_i (srst),
        .run_i  (nxt == ST_SETTLE),
        .load_i (enter_settle),
        .trim_i (st == ST_STBY),
        .fire_o (settle_done)
    );

    assign gbl_rst_o   = (st == ST_HOLD);
    assign cfg_load_o  = clears_cfg(st);
    assign conv_sync_o = sync_q;
    assign pwr_mode_o  = mode_of(st);
    assign drdy_n_o    = !settle_done;

    // R1: the global reset always reloads the defaults
    p_gbl_load_r1: assert property (@(posedge clk) disable iff (srst)
        gbl_rst_o |-> cfg_load_o);

    // R4: a reset command reaching the last serial edge loads defaults next cycle
    p_cmd_edge_r4: assert property (@(posedge clk) disable iff (srst)
        (req.cmd_fire && req.cmd == CMD_RESET) |=> cfg_load_o);

    // R5: the restart pulse is one cycle wide
    p_sync_pulse_r5: assert property (@(posedge clk) disable iff (srst)
        conv_sync_o |=> !conv_sync_o);

    // R6: data-ready appears only in the run mode
    p_drdy_run_r6: assert property (@(posedge clk) disable iff (srst)
        !drdy_n_o |-> (pwr_mode_o == MODE_RUN));

    // R8: a qualified power-down request forces the power-down mode
    p_pdn_mode_r8: assert property (@(posedge clk) disable iff (srst)
        (req.pdn_hold && req.por_ok) |=> (pwr_mode_o == MODE_PDN));

    // R9: standby never reports data and never clears the registers
    p_stby_quiet_r9: assert property (@(posedge clk) disable iff (srst)
        (pwr_mode_o == MODE_STBY) |-> (drdy_n_o && !cfg_load_o));

    // R10: a wake-up while running starts no new conversion sequence
    p_wake_ignored_r10: assert property (@(posedge clk) disable iff (srst)
        (st == ST_RUN && req.cmd_fire && req.cmd == CMD_WAKE
         && !req.pdn_hold && !req.rst_hold) |=> !conv_sync_o);

endmodule

// File: tb/cseq_top_tb.sv
module cseq_top_tb_top;

    localparam int POR = 20;
    localparam int SET = 12;

    logic       clk = 1'b0;
    logic       sup_ana_ok_i = 1'b0;
    logic       sup_dig_ok_i = 1'b0;
    logic       rst_pin_n_i = 1'b1;
    logic       pdn_pin_n_i = 1'b1;
    logic [1:0] cmd_code_i = 2'd0;
    logic [3:0] sclk_edges_i = 4'd0;
    logic       gbl_rst_o, cfg_load_o, conv_sync_o, drdy_n_o;
    logic [1:0] pwr_mode_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cseq_top #(.POR_CYCLES(POR), .SETTLE_CYCLES(SET)) dut_i (
        .clk          (clk),
        .sup_ana_ok_i (sup_ana_ok_i),
        .sup_dig_ok_i (sup_dig_ok_i),
        .rst_pin_n_i  (rst_pin_n_i),
        .pdn_pin_n_i  (pdn_pin_n_i),
        .cmd_code_i   (cmd_code_i),
        .sclk_edges_i (sclk_edges_i),
        .gbl_rst_o    (gbl_rst_o),
        .cfg_load_o   (cfg_load_o),
        .conv_sync_o  (conv_sync_o),
        .pwr_mode_o   (pwr_mode_o),
        .drdy_n_o     (drdy_n_o)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic await_sync(string req, int limit);
        int w = 0;
        while (!conv_sync_o && w < limit) begin
            tick();
            w++;
        end
        check(conv_sync_o == 1'b1, req, "sync pulse seen", int'(conv_sync_o), 1);
    endtask

    task automatic settle_from_sync(int len, string req);
        int waited = 0;
        while (drdy_n_o == 1'b1 && waited < 4 * len) begin
            tick();
            waited++;
        end
        check(waited == len, req, "cycles from sync to data-ready", waited, len);
        tick();
        check(drdy_n_o == 1'b1 && pwr_mode_o == 2'd0, req, "strobe width and run mode",
              int'(drdy_n_o), 1);
    endtask

    task automatic send_cmd(logic [1:0] code);
        cmd_code_i   = code;
        sclk_edges_i = 4'd8;
        tick();
    endtask

    task automatic clear_cmd();
        cmd_code_i   = 2'd0;
        sclk_edges_i = 4'd0;
    endtask

    task automatic count_por(string req);
        int highs = 0;
        tick();
        while (gbl_rst_o && highs < 3 * POR) begin
            highs++;
            tick();
        end
        check(highs == POR, req, "global reset samples after supplies good", highs, POR);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int bad;
        repeat (5) tick();

        // R1: reset state with supplies missing
        check(gbl_rst_o == 1'b1, "R1", "gbl reset at start", int'(gbl_rst_o), 1);
        check(cfg_load_o == 1'b1, "R1", "cfg load at start", int'(cfg_load_o), 1);
        check(pwr_mode_o == 2'd3, "R1", "mode at start", int'(pwr_mode_o), 3);
        check(drdy_n_o == 1'b1 && conv_sync_o == 1'b0, "R1", "quiet outputs at start",
              int'(drdy_n_o), 1);

        // R2: analog supply alone never releases
        sup_ana_ok_i = 1'b1;
        bad = 0;
        for (int i = 0; i < POR + 5; i++) begin
            tick();
            if (!gbl_rst_o) bad++;
        end
        check(bad == 0, "R2", "release with one supply", bad, 0);

        // R1: exact hold length, then R5/R6 first settle
        sup_dig_ok_i = 1'b1;
        count_por("R1");
        check(conv_sync_o == 1'b1, "R5", "sync after power-on", int'(conv_sync_o), 1);
        settle_from_sync(SET, "R6");

        // R3: pin width sweep
        for (int w = 1; w <= 4; w++) begin
            int saw = 0;
            rst_pin_n_i = 1'b0;
            for (int i = 0; i < w; i++) begin
                tick();
                if (cfg_load_o) saw = 1;
            end
            rst_pin_n_i = 1'b1;
            for (int i = 0; i < 10 && !conv_sync_o; i++) begin
                tick();
                if (cfg_load_o) saw = 1;
            end
            check(saw == (w >= 2 ? 1 : 0), "R3", $sformatf("reset from width %0d", w),
                  saw, (w >= 2 ? 1 : 0));
            if (w >= 2) begin
                check(conv_sync_o == 1'b1, "R5", "sync after pin reset", int'(conv_sync_o), 1);
                settle_from_sync(SET, "R6");
            end else begin
                check(conv_sync_o == 1'b0 && pwr_mode_o == 2'd0, "R3",
                      "short pulse leaves run", int'(pwr_mode_o), 0);
            end
        end

        // R3: long hold keeps reset while low
        rst_pin_n_i = 1'b0;
        repeat (10) tick();
        check(cfg_load_o == 1'b1 && pwr_mode_o == 2'd3, "R3", "held in reset",
              int'(pwr_mode_o), 3);
        rst_pin_n_i = 1'b1;
        await_sync("R5", 8);
        settle_from_sync(SET, "R6");

        // R4: edge counts 0..7 ignored, 8 acts on the next edge
        cmd_code_i = 2'd1;
        bad = 0;
        for (int e = 0; e < 8; e++) begin
            sclk_edges_i = 4'(e);
            tick();
            if (cfg_load_o || conv_sync_o) bad++;
        end
        check(bad == 0, "R4", "early serial edges", bad, 0);
        sclk_edges_i = 4'd8;
        tick();
        check(cfg_load_o == 1'b1, "R4", "load after eighth edge", int'(cfg_load_o), 1);
        tick();
        check(cfg_load_o == 1'b0, "R4", "load one cycle", int'(cfg_load_o), 0);
        check(conv_sync_o == 1'b1, "R5", "sync after command reset", int'(conv_sync_o), 1);
        // R11: command still present during the whole settle
        settle_from_sync(SET, "R11");
        clear_cmd();
        tick();

        // R9: standby
        send_cmd(2'd2);
        check(pwr_mode_o == 2'd1 && cfg_load_o == 1'b0, "R9", "standby entered",
              int'(pwr_mode_o), 1);
        clear_cmd();
        bad = 0;
        for (int i = 0; i < SET + 4; i++) begin
            tick();
            if (pwr_mode_o != 2'd1 || !drdy_n_o || cfg_load_o) bad++;
        end
        check(bad == 0, "R9", "standby stays quiet", bad, 0);
        send_cmd(2'd1);
        check(cfg_load_o == 1'b1, "R9", "reset accepted in standby", int'(cfg_load_o), 1);
        clear_cmd();
        tick();
        check(conv_sync_o == 1'b1, "R9", "restart after standby reset", int'(conv_sync_o), 1);
        settle_from_sync(SET, "R6");

        // R7: wake-up settles two cycles faster
        send_cmd(2'd2);
        clear_cmd();
        tick();
        send_cmd(2'd3);
        check(conv_sync_o == 1'b1, "R5", "sync on wake-up", int'(conv_sync_o), 1);
        settle_from_sync(SET - 2, "R7");
        clear_cmd();
        tick();

        // R10: wake-up while running
        send_cmd(2'd3);
        clear_cmd();
        bad = 0;
        for (int i = 0; i < SET + 4; i++) begin
            if (conv_sync_o || !drdy_n_o || pwr_mode_o != 2'd0) bad++;
            tick();
        end
        check(bad == 0, "R10", "wake-up in run ignored", bad, 0);

        // R8: power-down pin
        pdn_pin_n_i = 1'b0;
        repeat (6) tick();
        check(pwr_mode_o == 2'd2 && cfg_load_o == 1'b1, "R8", "power-down mode",
              int'(pwr_mode_o), 2);
        pdn_pin_n_i = 1'b1;
        await_sync("R8", 8);
        settle_from_sync(SET, "R8");

        // R1/R2: supply drop and reverse order
        sup_ana_ok_i = 1'b0;
        tick();
        check(gbl_rst_o == 1'b1 && pwr_mode_o == 2'd3, "R1", "supply drop resets",
              int'(gbl_rst_o), 1);
        bad = 0;
        for (int i = 0; i < POR + 5; i++) begin
            tick();
            if (!gbl_rst_o) bad++;
        end
        check(bad == 0, "R2", "digital supply alone", bad, 0);
        sup_ana_ok_i = 1'b1;
        count_por("R2");
        settle_from_sync(SET, "R6");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule